// File: doc/BRIEF.md
# Step-Based Vector Burst Sequencer

This block walks a burst of test vectors as a chain of steps. A small step table holds each step. A step names a block of vector memory by a word-aligned start offset and a vector count. It also carries a last-step marker, a return marker, and one control statement made of an action, a condition, a target step and a loop count. After a start pulse the sequencer runs from step 0. It emits the step's vector addresses, one per clock, and collects the per-vector fail reply into a step status and a burst status.

After the last vector of a step there is one evaluation cycle. In that cycle the control statement picks the next step. It can continue, jump, call a subroutine through a one-entry return stack, loop back a programmed number of times, or stop. The condition can test step status, burst status, or one of four external control resource lines.

The step table is loaded through a plain write port that refuses badly formed entries. Vector memory contents, edge timing and the host register layer sit outside this block.

Top module: `vec_burst_seq`

## Requirements
- R1: A table write with `cfg_we` high is stored only when `cfg_offset[1:0]` is 0 and `cfg_count` is nonzero. Otherwise the entry at `cfg_idx` keeps its old contents, and `cfg_err` is high for exactly the cycle after the write.
- R2: A `start` pulse while idle begins a burst at step 0 and clears the burst status. `busy` rises on the next cycle and stays high until the sequencer is idle again.
- R3: A step with offset O and count N drives `vec_valid` high for N consecutive cycles with `vec_addr` = O, O+1, …, O+N-1. One evaluation cycle with `vec_valid` low follows. Different steps may name overlapping or identical ranges.
- R4: A step fails if `vec_fail` is high in any cycle where `vec_valid` is high during that step. Step status is cleared at each step's start. The burst fails if any of its steps failed, and `burst_fail` shows the burst status.
- R5: Condition codes: 0 always, 1 pass, 2 not pass, 3 fail, 4 not fail, 5 burst pass, 6 burst fail, 7–10 control resource 0–3 high, 11–14 control resource 0–3 low, 15 never. The condition is sampled in the evaluation cycle and includes the step's final vector.
- R6: Action codes: 0 continue, 1 jump, 2 call, 3 loop, 4 stop. An action whose condition is false acts as continue. A taken jump goes to the target step.
- R7: A taken call saves the following step index in a one-entry return stack and goes to the target. When a step with the return marker is not redirected by its own action, it goes to the saved index if the stack is full, and the stack empties.
- R8: A taken loop with count K jumps to the target K times in succession. When the count is exhausted, or when K is 0, the step proceeds as if the action were continue.
- R9: The burst ends after a step whose action is not redirecting and which has its last-step marker set, or after a taken stop. The sequencer then goes idle, `done` pulses for one cycle, and `burst_fail` holds until the next start. A taken jump from a last step does not end the burst.
- R10: A step that does not redirect and is not last continues to the next step index, which wraps at the table size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Step table write strobe |
| cfg_idx | input | 3 | Step index written |
| cfg_offset | input | 12 | Vector start offset, multiple of 4 |
| cfg_count | input | 8 | Vector count, nonzero |
| cfg_last | input | 1 | Last-step marker |
| cfg_ret | input | 1 | Return marker |
| cfg_action | input | 3 | Control action code |
| cfg_cond | input | 4 | Condition code |
| cfg_target | input | 3 | Target step for jump, call, loop |
| cfg_loops | input | 4 | Loop repeat count |
| cfg_err | output | 1 | Rejected write, one cycle after it |
| start | input | 1 | Begin a burst when idle |
| ctrl_res | input | 4 | External control resources |
| vec_fail | input | 1 | Fail reply for the vector shown this cycle |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst end |
| burst_fail | output | 1 | Burst status |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | 12 | Vector memory address |
| step_idx | output | 3 | Step currently executing |

## Verification
The bench first aims at the evaluation cycle, where the condition has to see the fail of the step's final vector. A design that samples one cycle early would take the wrong branch when the failing vector comes last. It then separates step status from burst status: a step that passes after a failing one must not test as failed, and a design that forgets to clear step status would take a branch it should skip. A call into a subroutine that returns, and a loop that repeats a fixed number of times, are checked through the exact address stream, so an off-by-one repeat count or a lost return index shows up as missing or extra addresses. Rejected writes, jumps out of a last step, and a stop on a non-last step cover the remaining ways a burst can end too early or too late.

// File: rtl/seq_pkg.sv
// Shared codes for the vector burst sequencer.
// Assumes: action and condition fields are 3 and 4 bits wide.
package seq_pkg;
    localparam int ACT_W  = 3;
    localparam int COND_W = 4;

    localparam logic [ACT_W-1:0] ACT_CONT = 3'd0;
    localparam logic [ACT_W-1:0] ACT_JUMP = 3'd1;
    localparam logic [ACT_W-1:0] ACT_CALL = 3'd2;
    localparam logic [ACT_W-1:0] ACT_LOOP = 3'd3;
    localparam logic [ACT_W-1:0] ACT_STOP = 3'd4;

    localparam logic [COND_W-1:0] CND_ALWAYS  = 4'd0;
    localparam logic [COND_W-1:0] CND_PASS    = 4'd1;
    localparam logic [COND_W-1:0] CND_NPASS   = 4'd2;
    localparam logic [COND_W-1:0] CND_FAIL    = 4'd3;
    localparam logic [COND_W-1:0] CND_NFAIL   = 4'd4;
    localparam logic [COND_W-1:0] CND_BPASS   = 4'd5;
    localparam logic [COND_W-1:0] CND_BFAIL   = 4'd6;
    localparam logic [COND_W-1:0] CND_RES_HI0 = 4'd7;
    localparam logic [COND_W-1:0] CND_RES_LO0 = 4'd11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EVAL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/seq_step_table.sv
// Step table: register storage for every step plus the checking write port.
// Assumes: one write per cycle; reads are combinational at rd_idx.
// Reset leaves every step as a single vector at offset 0, last, continue.
module seq_step_table
    import seq_pkg::*;
#(
    parameter int STEPS  = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 8,
    parameter int LOOP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_off,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic              wr_last,
    input  logic              wr_ret,
    input  logic [ACT_W-1:0]  wr_act,
    input  logic [COND_W-1:0] wr_cond,
    input  logic [IDX_W-1:0]  wr_tgt,
    input  logic [LOOP_W-1:0] wr_loops,
    output logic              wr_reject,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_off,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic              rd_last,
    output logic              rd_ret,
    output logic [ACT_W-1:0]  rd_act,
    output logic [COND_W-1:0] rd_cond,
    output logic [IDX_W-1:0]  rd_tgt,
    output logic [LOOP_W-1:0] rd_loops
);
    logic [ADDR_W-1:0] off_q   [STEPS];
    logic [CNT_W-1:0]  cnt_q   [STEPS];
    logic              last_q  [STEPS];
    logic              ret_q   [STEPS];
    logic [ACT_W-1:0]  act_q   [STEPS];
    logic [COND_W-1:0] cond_q  [STEPS];
    logic [IDX_W-1:0]  tgt_q   [STEPS];
    logic [LOOP_W-1:0] loops_q [STEPS];

    logic bad_entry;

    // Flag an entry whose offset is not word aligned or whose count is zero.
    always_comb begin
        bad_entry = (wr_off[1:0] != 2'b00) || (wr_cnt == '0);
    end

    // One register slice per step; a slice loads only on a good write to it.
    for (genvar s = 0; s < STEPS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_q[s]   <= '0;
                cnt_q[s]   <= CNT_W'(1);
                last_q[s]  <= 1'b1;
                ret_q[s]   <= 1'b0;
                act_q[s]   <= ACT_CONT;
                cond_q[s]  <= CND_ALWAYS;
                tgt_q[s]   <= '0;
                loops_q[s] <= '0;
            end else if (wr_en && !bad_entry && (wr_idx == IDX_W'(s))) begin
                off_q[s]   <= wr_off;
                cnt_q[s]   <= wr_cnt;
                last_q[s]  <= wr_last;
                ret_q[s]   <= wr_ret;
                act_q[s]   <= wr_act;
                cond_q[s]  <= wr_cond;
                tgt_q[s]   <= wr_tgt;
                loops_q[s] <= wr_loops;
            end
        end
    end

    // Registered reject flag, one cycle after the offending write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_reject <= 1'b0;
        else        wr_reject <= wr_en && bad_entry;
    end

    // Combinational read of the addressed step.
    always_comb begin
        rd_off   = off_q[rd_idx];
        rd_cnt   = cnt_q[rd_idx];
        rd_last  = last_q[rd_idx];
        rd_ret   = ret_q[rd_idx];
        rd_act   = act_q[rd_idx];
        rd_cond  = cond_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
        rd_loops = loops_q[rd_idx];
    end

    // R1: a refused write leaves the stored offset and count untouched
    a_r1_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bad_entry) |=> (off_q[$past(wr_idx)] == $past(off_q[wr_idx]))
                               && (cnt_q[$past(wr_idx)] == $past(cnt_q[wr_idx])));

    // R1: a stored count is never zero
    a_r1_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt != '0);
endmodule

// File: rtl/seq_cond_eval.sv
// Condition evaluator: maps a condition code onto step status, burst status
// and the external control resource lines.
// Assumes: NUM_RES resources; code 15 and unused codes evaluate false.
module seq_cond_eval
    import seq_pkg::*;
#(
    parameter int NUM_RES = 4
) (
    input  logic [COND_W-1:0]  cond,
    input  logic               step_fail,
    input  logic               burst_fail,
    input  logic [NUM_RES-1:0] ctrl_res,
    output logic               hit
);
    // Decode the fixed status conditions, then the per-resource ones.
    always_comb begin
        hit = 1'b0;
        case (cond)
            CND_ALWAYS: hit = 1'b1;
            CND_PASS:   hit = !step_fail;
            CND_NPASS:  hit = step_fail;
            CND_FAIL:   hit = step_fail;
            CND_NFAIL:  hit = !step_fail;
            CND_BPASS:  hit = !burst_fail;
            CND_BFAIL:  hit = burst_fail;
            default:    hit = 1'b0;
        endcase
        for (int r = 0; r < NUM_RES; r++) begin
            if (cond == COND_W'(int'(CND_RES_HI0) + r)) hit = ctrl_res[r];
            if (cond == COND_W'(int'(CND_RES_LO0) + r)) hit = !ctrl_res[r];
        end
    end
endmodule

// File: rtl/seq_flow_ctrl.sv
// Flow control: picks the step that follows the one just finished, and
// keeps the one-entry return stack and the loop repeat counter.
// Assumes: eval_en is high for exactly one cycle per finished step; clear
// marks burst start. One loop may be active at a time.
module seq_flow_ctrl
    import seq_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int LOOP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              eval_en,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [ACT_W-1:0]  act,
    input  logic              cond_hit,
    input  logic              ret_flag,
    input  logic              last_flag,
    input  logic [IDX_W-1:0]  target,
    input  logic [LOOP_W-1:0] loops,
    output logic [IDX_W-1:0]  nxt_idx,
    output logic              finish
);
    logic              ret_vld;
    logic [IDX_W-1:0]  ret_addr;
    logic              loop_act;
    logic [LOOP_W-1:0] loop_left;

    logic [ACT_W-1:0]  eff_act;
    logic              redirected;
    logic              push, pop;
    logic              lp_load, lp_dec, lp_end;
    logic [IDX_W-1:0]  seq_next;

    // Next index in table order, wrapping at the top.
    always_comb begin
        seq_next = cur_idx + 1'b1;
    end

    // Choose the successor step and the stack and loop updates.
    always_comb begin
        eff_act    = cond_hit ? act : ACT_CONT;
        redirected = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        lp_load    = 1'b0;
        lp_dec     = 1'b0;
        lp_end     = 1'b0;
        finish     = 1'b0;
        nxt_idx    = seq_next;
        case (eff_act)
            ACT_JUMP: begin
                redirected = 1'b1;
                nxt_idx    = target;
            end
            ACT_CALL: begin
                redirected = 1'b1;
                push       = 1'b1;
                nxt_idx    = target;
            end
            ACT_STOP: begin
                redirected = 1'b1;
                finish     = 1'b1;
            end
            ACT_LOOP: begin
                if (!loop_act) begin
                    if (loops != '0) begin
                        lp_load    = 1'b1;
                        redirected = 1'b1;
                        nxt_idx    = target;
                    end
                end else if (loop_left != '0) begin
                    lp_dec     = 1'b1;
                    redirected = 1'b1;
                    nxt_idx    = target;
                end else begin
                    lp_end = 1'b1;
                end
            end
            default: ;
        endcase
        if (!redirected) begin
            if (ret_flag && ret_vld) begin
                pop     = 1'b1;
                nxt_idx = ret_addr;
            end else if (last_flag) begin
                finish = 1'b1;
            end
        end
    end

    // Return stack: filled by a call, emptied by a return or burst start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ret_vld  <= 1'b0;
            ret_addr <= '0;
        end else if (eval_en && push) begin
            ret_vld  <= 1'b1;
            ret_addr <= seq_next;
        end else if (eval_en && pop) begin
            ret_vld  <= 1'b0;
        end
    end

    // Loop counter: loaded on the first pass, counted down on each repeat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            loop_act  <= 1'b0;
            loop_left <= '0;
        end else if (eval_en && lp_load) begin
            loop_act  <= 1'b1;
            loop_left <= loops - 1'b1;
        end else if (eval_en && lp_dec) begin
            loop_left <= loop_left - 1'b1;
        end else if (eval_en && lp_end) begin
            loop_act  <= 1'b0;
        end
    end

    // R7: a taken call leaves the stack holding the step after the caller
    a_r7_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && !clear && cond_hit && act == ACT_CALL)
            |=> ret_vld && (ret_addr == IDX_W'($past(cur_idx) + 1'b1)));

    // R7: a return taken from a full stack empties it
    a_r7_return_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && !clear && ret_vld && ret_flag && !cond_hit)
            |=> !ret_vld);

    // R8: the repeat counter only counts down while a loop is active
    a_r8_loop_down: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_act && $past(loop_act) && !$past(clear) && $past(rst_n))
            |-> loop_left <= $past(loop_left));
endmodule

// File: rtl/vec_burst_seq.sv
// Vector burst sequencer top: steps through the step table, emits one vector
// address per cycle, gathers step and burst fail status, and spends one
// evaluation cycle per step deciding where to go next.
// Assumes: vec_fail answers the address shown in the same cycle;
// CNT_W <= ADDR_W; start is ignored while busy.
module vec_burst_seq
    import seq_pkg::*;
#(
    parameter int STEPS   = 8,
    parameter int ADDR_W  = 12,
    parameter int CNT_W   = 8,
    parameter int LOOP_W  = 4,
    parameter int NUM_RES = 4,
    localparam int IDX_W  = $clog2(STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [ADDR_W-1:0]  cfg_offset,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               cfg_last,
    input  logic               cfg_ret,
    input  logic [2:0]         cfg_action,
    input  logic [3:0]         cfg_cond,
    input  logic [IDX_W-1:0]   cfg_target,
    input  logic [LOOP_W-1:0]  cfg_loops,
    output logic               cfg_err,
    input  logic               start,
    input  logic [NUM_RES-1:0] ctrl_res,
    input  logic               vec_fail,
    output logic               busy,
    output logic               done,
    output logic               burst_fail,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [IDX_W-1:0]   step_idx
);
    seq_state_e        state_q;
    logic [IDX_W-1:0]  cur_q;
    logic [CNT_W-1:0]  vcnt_q;
    logic              step_fail_q;
    logic              burst_fail_q;
    logic              done_q;

    logic [ADDR_W-1:0] t_off;
    logic [CNT_W-1:0]  t_cnt;
    logic              t_last, t_ret;
    logic [ACT_W-1:0]  t_act;
    logic [COND_W-1:0] t_cond;
    logic [IDX_W-1:0]  t_tgt;
    logic [LOOP_W-1:0] t_loops;

    logic              cond_hit;
    logic [IDX_W-1:0]  nxt_idx;
    logic              finish;
    logic              launch;
    logic              eval_en;
    logic              last_vec;

    seq_step_table #(
        .STEPS(STEPS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .LOOP_W(LOOP_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_off   (cfg_offset),
        .wr_cnt   (cfg_count),
        .wr_last  (cfg_last),
        .wr_ret   (cfg_ret),
        .wr_act   (cfg_action),
        .wr_cond  (cfg_cond),
        .wr_tgt   (cfg_target),
        .wr_loops (cfg_loops),
        .wr_reject(cfg_err),
        .rd_idx   (cur_q),
        .rd_off   (t_off),
        .rd_cnt   (t_cnt),
        .rd_last  (t_last),
        .rd_ret   (t_ret),
        .rd_act   (t_act),
        .rd_cond  (t_cond),
        .rd_tgt   (t_tgt),
        .rd_loops (t_loops)
    );

    seq_cond_eval #(.NUM_RES(NUM_RES)) cond_i (
        .cond      (t_cond),
        .step_fail (step_fail_q),
        .burst_fail(burst_fail_q),
        .ctrl_res  (ctrl_res),
        .hit       (cond_hit)
    );

    seq_flow_ctrl #(.IDX_W(IDX_W), .LOOP_W(LOOP_W)) flow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (launch),
        .eval_en  (eval_en),
        .cur_idx  (cur_q),
        .act      (t_act),
        .cond_hit (cond_hit),
        .ret_flag (t_ret),
        .last_flag(t_last),
        .target   (t_tgt),
        .loops    (t_loops),
        .nxt_idx  (nxt_idx),
        .finish   (finish)
    );

    // Phase strobes derived from the current state.
    always_comb begin
        launch   = (state_q == ST_IDLE) && start;
        eval_en  = (state_q == ST_EVAL);
        last_vec = (vcnt_q == CNT_W'(t_cnt - 1'b1));
    end

    // Main sequencing: idle, vector run, evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cur_q        <= '0;
            vcnt_q       <= '0;
            step_fail_q  <= 1'b0;
            burst_fail_q <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q      <= ST_RUN;
                        cur_q        <= '0;
                        vcnt_q       <= '0;
                        step_fail_q  <= 1'b0;
                        burst_fail_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (vec_fail) begin
                        step_fail_q  <= 1'b1;
                        burst_fail_q <= 1'b1;
                    end
                    if (last_vec) state_q <= ST_EVAL;
                    else          vcnt_q  <= vcnt_q + 1'b1;
                end
                ST_EVAL: begin
                    if (finish) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q     <= ST_RUN;
                        cur_q       <= nxt_idx;
                        vcnt_q      <= '0;
                        step_fail_q <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output mapping.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        burst_fail = burst_fail_q;
        vec_valid  = (state_q == ST_RUN);
        vec_addr   = t_off + ADDR_W'(vcnt_q);
        step_idx   = cur_q;
    end

    // R2: a start while idle raises busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3: back-to-back valid vectors always step the address by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(vec_valid) && $past(rst_n))
            |-> vec_addr == ADDR_W'($past(vec_addr) + 1'b1));

    // R4: burst status never drops while a burst runs
    a_r4_burst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(burst_fail) && $past(rst_n)) |-> burst_fail);

    // R4: a reported fail on a valid vector is reflected in burst status
    a_r4_fail_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_fail) |=> burst_fail);

    // R9: done appears only with the sequencer idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !vec_valid);
endmodule

// File: tb/vec_burst_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: a model task predicts the address stream and final burst
// status from the requirements and queues them; a monitor pops and compares.
module vec_burst_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [11:0] cfg_offset = '0;
    logic [7:0]  cfg_count = '0;
    logic        cfg_last = 1'b0;
    logic        cfg_ret = 1'b0;
    logic [2:0]  cfg_action = '0;
    logic [3:0]  cfg_cond = '0;
    logic [2:0]  cfg_target = '0;
    logic [3:0]  cfg_loops = '0;
    logic        cfg_err;
    logic        start = 1'b0;
    logic [3:0]  ctrl_res = '0;
    logic        vec_fail;
    logic        busy, done, burst_fail, vec_valid;
    logic [11:0] vec_addr;
    logic [2:0]  step_idx;

    int          fail_a = 4095;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cycles = 0;

    logic [11:0] exp_q[$];
    string       cur_req = "R3";

    int  m_off[8], m_cnt[8], m_act[8], m_cond[8], m_tgt[8], m_loops[8];
    bit  m_last[8], m_ret[8];

    always #2.5 clk = ~clk;

    assign vec_fail = vec_valid && (int'(vec_addr) == fail_a);

    vec_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_offset(cfg_offset),
        .cfg_count(cfg_count), .cfg_last(cfg_last), .cfg_ret(cfg_ret),
        .cfg_action(cfg_action), .cfg_cond(cfg_cond), .cfg_target(cfg_target),
        .cfg_loops(cfg_loops), .cfg_err(cfg_err),
        .start(start), .ctrl_res(ctrl_res), .vec_fail(vec_fail),
        .busy(busy), .done(done), .burst_fail(burst_fail),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .step_idx(step_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    // Monitor: every valid vector must match the head of the queue (R3).
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                check({cur_req, " extra vector"}, int'(vec_addr), -1);
            end else begin
                check(cur_req, int'(vec_addr), int'(exp_q.pop_front()));
            end
        end
    end

    // R1 write with expected reject outcome; model follows only good writes.
    task automatic wcfg(input int idx, input int off, input int cnt, input bit last,
                        input bit ret, input int act, input int cond, input int tgt,
                        input int loops);
        bit bad;
        bad = (off % 4 != 0) || (cnt == 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_offset = 12'(off); cfg_count = 8'(cnt);
        cfg_last = last; cfg_ret = ret; cfg_action = 3'(act); cfg_cond = 4'(cond);
        cfg_target = 3'(tgt); cfg_loops = 4'(loops);
        @(negedge clk);
        cfg_we = 1'b0;
        check("R1 cfg_err", int'(cfg_err), int'(bad));
        if (!bad) begin
            m_off[idx] = off; m_cnt[idx] = cnt; m_last[idx] = last; m_ret[idx] = ret;
            m_act[idx] = act; m_cond[idx] = cond; m_tgt[idx] = tgt; m_loops[idx] = loops;
        end
    endtask

    function automatic bit cond_true(input int c, input bit sf, input bit bf);
        case (c)
            0: return 1'b1;
            1: return !sf;
            2: return sf;
            3: return sf;
            4: return !sf;
            5: return !bf;
            6: return bf;
            7, 8, 9, 10: return ctrl_res[c-7];
            11, 12, 13, 14: return !ctrl_res[c-11];
            default: return 1'b0;
        endcase
    endfunction

    // Requirement model (R3..R10): predicts addresses and final burst status.
    task automatic model(output bit bf);
        int cur, nxt, guard, left;
        bit sf, rv, la, redir, fin;
        int ra;
        cur = 0; bf = 0; rv = 0; la = 0; left = 0; ra = 0;
        for (guard = 0; guard < 200; guard++) begin
            sf = 0;
            for (int i = 0; i < m_cnt[cur]; i++) begin
                exp_q.push_back(12'(m_off[cur] + i));
                if (m_off[cur] + i == fail_a) sf = 1;
            end
            bf |= sf;
            redir = 0; fin = 0; nxt = (cur + 1) % 8;
            if (cond_true(m_cond[cur], sf, bf)) begin
                case (m_act[cur])
                    1: begin redir = 1; nxt = m_tgt[cur]; end
                    2: begin redir = 1; rv = 1; ra = (cur + 1) % 8; nxt = m_tgt[cur]; end
                    4: begin redir = 1; fin = 1; end
                    3: begin
                        if (!la) begin
                            if (m_loops[cur] != 0) begin
                                la = 1; left = m_loops[cur] - 1; redir = 1; nxt = m_tgt[cur];
                            end
                        end else if (left != 0) begin
                            left--; redir = 1; nxt = m_tgt[cur];
                        end else la = 0;
                    end
                    default: ;
                endcase
            end
            if (!redir) begin
                if (m_ret[cur] && rv) begin rv = 0; nxt = ra; end
                else if (m_last[cur]) fin = 1;
            end
            if (fin) return;
            cur = nxt;
        end
    endtask

    // Run one burst: predict, start, watch busy, then check end state.
    task automatic run_burst(input string req);
        bit bf;
        int waited;
        cur_req = req;
        model(bf);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 3000) begin
            if (!busy) begin
                check({req, " R2 busy held"}, int'(busy), 1);
                break;
            end
            @(negedge clk);
            waited++;
        end
        check({req, " R9 done"}, int'(done), 1);
        check({req, " R9 idle"}, int'(busy), 0);
        check({req, " R4 burst_fail"}, int'(burst_fail), int'(bf));
        check({req, " R3 missing vectors"}, exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check({req, " R9 done one cycle"}, int'(done), 0);
        check({req, " R9 burst_fail held"}, int'(burst_fail), int'(bf));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_off[i] = 0; m_cnt[i] = 1; m_last[i] = 1; m_ret[i] = 0;
            m_act[i] = 0; m_cond[i] = 0; m_tgt[i] = 0; m_loops[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R2 reset busy", int'(busy), 0);
        check("R3 reset vec_valid", int'(vec_valid), 0);
        check("R9 reset done", int'(done), 0);
        check("R1 reset cfg_err", int'(cfg_err), 0);

        // R3 / R10: continue then last, identical start offsets
        wcfg(0, 0, 3, 0, 0, 0, 0, 0, 0);
        wcfg(1, 0, 2, 1, 0, 0, 0, 0, 0);
        run_burst("R10 continue");

        // R1: misaligned offset and zero count are refused; rerun unchanged
        wcfg(1, 6, 4, 1, 0, 0, 0, 0, 0);
        wcfg(1, 8, 0, 1, 0, 0, 0, 0, 0);
        run_burst("R1 rejected unchanged");

        // R5 / R6: jump on step fail, fail on the step's final vector
        wcfg(0, 16, 4, 0, 0, 1, 3, 2, 0);
        wcfg(1, 32, 1, 1, 0, 0, 0, 0, 0);
        wcfg(2, 48, 2, 1, 0, 0, 0, 0, 0);
        fail_a = 19;
        run_burst("R6 jump taken");
        fail_a = 4095;
        run_burst("R6 false acts as continue");

        // R7: call into subroutine, return to the step after the caller
        wcfg(0, 0, 1, 0, 0, 2, 0, 3, 0);
        wcfg(1, 8, 1, 1, 0, 0, 0, 0, 0);
        wcfg(3, 40, 2, 0, 1, 0, 0, 0, 0);
        run_burst("R7 call return");

        // R8: loop back twice over a two-step body
        wcfg(0, 100, 1, 0, 0, 0, 0, 0, 0);
        wcfg(1, 104, 2, 1, 0, 3, 0, 0, 2);
        run_burst("R8 loop");
        // R8: loop count zero continues at once
        wcfg(1, 104, 2, 1, 0, 3, 0, 0, 0);
        run_burst("R8 loop zero");

        // R9: stop on a step without the last marker
        wcfg(0, 4, 2, 0, 0, 4, 0, 0, 0);
        run_burst("R9 stop");

        // R5: control resource 2 low condition
        wcfg(0, 0, 1, 0, 0, 1, 13, 5, 0);
        wcfg(1, 8, 1, 1, 0, 0, 0, 0, 0);
        wcfg(5, 200, 1, 1, 0, 0, 0, 0, 0);
        ctrl_res = 4'b0100;
        run_burst("R5 resource high");
        ctrl_res = 4'b0000;
        run_burst("R5 resource low");

        // R4: burst fail survives into a later passing step; R9 jump from last step
        wcfg(0, 12, 2, 0, 0, 0, 0, 0, 0);
        wcfg(1, 20, 1, 1, 0, 1, 6, 4, 0);
        wcfg(4, 60, 1, 1, 0, 0, 0, 0, 0);
        fail_a = 12;
        run_burst("R4 burst fail jump");
        // R4: step status cleared, so step 1 does not test as failed
        wcfg(1, 20, 1, 1, 0, 1, 3, 4, 0);
        run_burst("R4 step status cleared");
        fail_a = 4095;
        run_burst("R4 burst pass");

        summary();
    end
endmodule